// File: doc/BRIEF.md
# DRAM Fast-Access Page Fault Detector

This block sits beside an external memory controller and decides, for every external bus cycle, whether that cycle may use a fast DRAM access mode such as page, static column, nibble or serial. It keeps the address and the space code of the last cycle it accepted. It compares each new cycle against that history, under a set of independently enabled fault checks. The result is a registered, active-high grant, `fast_ok`. The grant is raised only when the history is valid and no enabled check finds a fault.

The checks cover four conditions. The first is a change of the page number, meaning the address bits selected by a programmable mask. The second is a break in a strictly incrementing address stream. The third is a change of either space-select pin, with each pin enabled on its own. The fourth applies after this device loses and regains the bus: with that check enabled, the history is dropped when the bus is lost. Three monitor enables choose the spaces for which the detector is active. A cycle in an unmonitored space receives no grant and leaves the history unchanged. The RAS/CAS timing itself belongs to the memory controller and is outside this block.

Top module: `dram_fast_grant`

## Requirements
- R1: After reset `fast_ok` is 0 and the history is invalid. The first qualifying monitored cycle after reset always yields `fast_ok` = 0.
- R2: Space codes are Y data = 2'b00, X data = 2'b01 and program = 2'b10. A strobed cycle with code 2'b11 is not an access: `fast_ok` and the history keep their values.
- R3: A qualifying cycle in a space whose monitor enable (`mon_ydat`, `mon_xdat`, `mon_prog`) is 0 gives `fast_ok` = 0 on the next clock and does not update the stored address or space.
- R4: A page fault occurs when `(addr ^ stored_addr) & page_mask` is nonzero. A page fault gives `fast_ok` = 0.
- R5: With `en_seq` = 1, a monitored cycle whose address is not the stored address plus one (modulo 2^ADDR_W) gives `fast_ok` = 0. With `en_seq` = 0, a non-incrementing address inside the page is accepted.
- R6: With `en_space_hi` = 1, a difference in space bit 1 between the stored and the current cycle gives `fast_ok` = 0. `en_space_lo` does the same for bit 0. A pin difference whose enable is 0 has no effect.
- R7: When `bus_owner` falls while `en_owner` = 1, the history becomes invalid, so the first monitored cycle after mastership returns gives `fast_ok` = 0. With `en_owner` = 0 the history survives the loss of the bus.
- R8: A clock on which `cyc_valid` = 0 or `bus_owner` = 0 changes neither `fast_ok` nor the history.
- R9: On a qualifying monitored cycle with valid history and no enabled fault, `fast_ok` becomes 1 on the next clock. Every monitored cycle stores its address and space, and the history becomes valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_valid | input | 1 | Strobe marking one external bus cycle |
| bus_owner | input | 1 | 1 while this device is bus master |
| addr | input | ADDR_W | Address of the current cycle |
| space | input | 2 | Space code (00 Y, 01 X, 10 program, 11 idle) |
| en_seq | input | 1 | Enable the sequential-address check |
| en_owner | input | 1 | Enable invalidation on loss of mastership |
| en_space_hi | input | 1 | Enable fault on change of space bit 1 |
| en_space_lo | input | 1 | Enable fault on change of space bit 0 |
| mon_prog | input | 1 | Monitor program-space cycles |
| mon_xdat | input | 1 | Monitor X-data cycles |
| mon_ydat | input | 1 | Monitor Y-data cycles |
| page_mask | input | ADDR_W | 1 bits select the page-number bits |
| fast_ok | output | 1 | Registered fast-access grant |

## Verification
A wrong stored address or space shows up at the grant one clock after the next monitored cycle. The grant then rises where a page, sequence or pin fault should hold it low, or falls on a clean continuation. A stale validity flag appears as a grant on the first cycle after reset or after a regain of the bus. A latch that wrongly updates on unmonitored or idle cycles appears one monitored cycle later, as a wrong sequential verdict. The randomized stream therefore keeps runs of incrementing addresses long, so each of these faults reaches `fast_ok` within a cycle or two.

// File: rtl/dfg_pkg.sv
package dfg_pkg;
   typedef enum logic [1:0] {
      SP_YDAT = 2'b00,
      SP_XDAT = 2'b01,
      SP_PROG = 2'b10,
      SP_IDLE = 2'b11
   } space_e;

   localparam int unsigned SPACE_PINS = 2;
endpackage

// File: rtl/dfg_space_sel.sv
module dfg_space_sel
   import dfg_pkg::*;
(
   input  logic [1:0] space,
   input  logic       mon_prog,
   input  logic       mon_xdat,
   input  logic       mon_ydat,
   output logic       is_access,
   output logic       monitored
);
   space_e sp;
   assign sp = space_e'(space);

   always_comb begin
      is_access = 1'b1;
      monitored = 1'b0;
      unique case (sp)
         SP_YDAT: monitored = mon_ydat;
         SP_XDAT: monitored = mon_xdat;
         SP_PROG: monitored = mon_prog;
         default: is_access = 1'b0;
      endcase
   end
endmodule

// File: rtl/dfg_history.sv
module dfg_history #(
   parameter int unsigned ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              drop,
   input  logic [ADDR_W-1:0] cur_addr,
   input  logic [1:0]        cur_space,
   output logic [ADDR_W-1:0] lat_addr,
   output logic [1:0]        lat_space,
   output logic              lat_valid
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_addr  <= '0;
         lat_space <= 2'b00;
         lat_valid <= 1'b0;
      end else if (load) begin
         lat_addr  <= cur_addr;
         lat_space <= cur_space;
         lat_valid <= 1'b1;
      end else if (drop) begin
         lat_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/dfg_fault_eval.sv
module dfg_fault_eval
   import dfg_pkg::*;
#(
   parameter int unsigned ADDR_W = 16
) (
   input  logic [ADDR_W-1:0] cur_addr,
   input  logic [1:0]        cur_space,
   input  logic [ADDR_W-1:0] lat_addr,
   input  logic [1:0]        lat_space,
   input  logic              lat_valid,
   input  logic [ADDR_W-1:0] page_mask,
   input  logic              en_seq,
   input  logic [1:0]        en_space,
   output logic              any_fault
);
   logic [ADDR_W-1:0]     seq_next;
   logic                  page_fault;
   logic                  seq_fault;
   logic [SPACE_PINS-1:0] pin_fault;

   assign seq_next   = lat_addr + {{(ADDR_W-1){1'b0}}, 1'b1};
   assign page_fault = |((cur_addr ^ lat_addr) & page_mask);
   assign seq_fault  = en_seq && (cur_addr != seq_next);

   for (genvar p = 0; p < SPACE_PINS; p++) begin : g_pin
      assign pin_fault[p] = en_space[p] & (cur_space[p] ^ lat_space[p]);
   end

   assign any_fault = !lat_valid || page_fault || seq_fault || (|pin_fault);
endmodule

// File: rtl/dram_fast_grant.sv
module dram_fast_grant #(
   parameter int unsigned ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cyc_valid,
   input  logic              bus_owner,
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        space,
   input  logic              en_seq,
   input  logic              en_owner,
   input  logic              en_space_hi,
   input  logic              en_space_lo,
   input  logic              mon_prog,
   input  logic              mon_xdat,
   input  logic              mon_ydat,
   input  logic [ADDR_W-1:0] page_mask,
   output logic              fast_ok
);
   if (ADDR_W < 2 || ADDR_W > 64) begin : g_bad_width
      $error("dram_fast_grant: ADDR_W must lie in 2..64");
   end

   logic              is_access;
   logic              monitored;
   logic              qualify;
   logic              owner_q;
   logic              owner_lost;
   logic              any_fault;
   logic [ADDR_W-1:0] lat_addr;
   logic [1:0]        lat_space;
   logic              lat_valid;

   dfg_space_sel u_sel (
      .space     (space),
      .mon_prog  (mon_prog),
      .mon_xdat  (mon_xdat),
      .mon_ydat  (mon_ydat),
      .is_access (is_access),
      .monitored (monitored)
   );

   assign qualify    = cyc_valid && bus_owner && is_access;
   assign owner_lost = owner_q && !bus_owner && en_owner;

   dfg_history #(.ADDR_W(ADDR_W)) u_hist (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (qualify && monitored),
      .drop      (owner_lost),
      .cur_addr  (addr),
      .cur_space (space),
      .lat_addr  (lat_addr),
      .lat_space (lat_space),
      .lat_valid (lat_valid)
   );

   dfg_fault_eval #(.ADDR_W(ADDR_W)) u_eval (
      .cur_addr  (addr),
      .cur_space (space),
      .lat_addr  (lat_addr),
      .lat_space (lat_space),
      .lat_valid (lat_valid),
      .page_mask (page_mask),
      .en_seq    (en_seq),
      .en_space  ({en_space_hi, en_space_lo}),
      .any_fault (any_fault)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         owner_q <= 1'b0;
         fast_ok <= 1'b0;
      end else begin
         owner_q <= bus_owner;
         if (qualify) begin
            fast_ok <= monitored && !any_fault;
         end
      end
   end
endmodule

// File: rtl/dram_fast_grant_chk.sv
module dram_fast_grant_chk #(
   parameter int unsigned ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cyc_valid,
   input logic              bus_owner,
   input logic [ADDR_W-1:0] addr,
   input logic [1:0]        space,
   input logic              en_seq,
   input logic              en_owner,
   input logic              mon_prog,
   input logic              mon_xdat,
   input logic              mon_ydat,
   input logic [ADDR_W-1:0] page_mask,
   input logic              fast_ok,
   input logic [ADDR_W-1:0] lat_addr,
   input logic              lat_valid
);
   logic qual;
   logic mon;
   assign qual = cyc_valid && bus_owner && (space != 2'b11);
   assign mon  = (space == 2'b00 && mon_ydat) || (space == 2'b01 && mon_xdat) ||
                 (space == 2'b10 && mon_prog);

   assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(cyc_valid && bus_owner) |=> $stable(fast_ok));

   assert_no_access_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_valid && space == 2'b11) |=> $stable(fast_ok) && $stable(lat_addr));

   assert_unmonitored_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (qual && !mon) |=> !fast_ok && $stable(lat_addr));

   assert_cold_history_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (qual && !lat_valid) |=> !fast_ok);

   assert_owner_loss_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(bus_owner) && en_owner) |=> !lat_valid);

   assert_page_cross_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (qual && mon && ((addr ^ lat_addr) & page_mask) != '0) |=> !fast_ok);

   assert_seq_break_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (qual && mon && en_seq && addr != lat_addr + 1'b1) |=> !fast_ok);

   assert_history_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (qual && mon) |=> lat_valid);
endmodule

bind dram_fast_grant dram_fast_grant_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cyc_valid (cyc_valid),
   .bus_owner (bus_owner),
   .addr      (addr),
   .space     (space),
   .en_seq    (en_seq),
   .en_owner  (en_owner),
   .mon_prog  (mon_prog),
   .mon_xdat  (mon_xdat),
   .mon_ydat  (mon_ydat),
   .page_mask (page_mask),
   .fast_ok   (fast_ok),
   .lat_addr  (lat_addr),
   .lat_valid (lat_valid)
);

// File: tb/dram_fast_grant_bench.sv
`timescale 1ns/1ps
module dram_fast_grant_bench;
   localparam int AW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cyc_valid = 1'b0, bus_owner = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [1:0]    space = 2'b00;
   logic          en_seq = 1'b1, en_owner = 1'b1, en_space_hi = 1'b1, en_space_lo = 1'b1;
   logic          mon_prog = 1'b1, mon_xdat = 1'b1, mon_ydat = 1'b1;
   logic [AW-1:0] page_mask = 16'hFFF0;
   logic          fast_ok;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   // bench model of the requirements
   logic          m_lv, m_t, m_oq;
   logic [AW-1:0] m_la;
   logic [1:0]    m_ls;

   always #10 clk = ~clk;

   dram_fast_grant #(.ADDR_W(AW)) u_dram_fast_grant (
      .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .bus_owner(bus_owner),
      .addr(addr), .space(space), .en_seq(en_seq), .en_owner(en_owner),
      .en_space_hi(en_space_hi), .en_space_lo(en_space_lo),
      .mon_prog(mon_prog), .mon_xdat(mon_xdat), .mon_ydat(mon_ydat),
      .page_mask(page_mask), .fast_ok(fast_ok)
   );

   function automatic logic monitored_f(input logic [1:0] sp);
      return (sp == 2'b00 && mon_ydat) || (sp == 2'b01 && mon_xdat) ||
             (sp == 2'b10 && mon_prog);
   endfunction

   function automatic logic faulty_f(input logic [AW-1:0] a, input logic [1:0] sp);
      logic [AW-1:0] nx;
      nx = m_la + 16'd1;
      return !m_lv || (((a ^ m_la) & page_mask) != '0) || (en_seq && a != nx) ||
             (en_space_hi && sp[1] != m_ls[1]) || (en_space_lo && sp[0] != m_ls[0]);
   endfunction

   task automatic model_step();
      logic q;
      q = cyc_valid && bus_owner && space != 2'b11;
      if (q) begin
         if (!monitored_f(space)) m_t = 1'b0;
         else begin
            m_t  = !faulty_f(addr, space);
            m_la = addr;
            m_ls = space;
            m_lv = 1'b1;
         end
      end
      if (m_oq && !bus_owner && en_owner) m_lv = 1'b0;
      m_oq = bus_owner;
   endtask

   task automatic check(input string tag);
      checks++;
      if (fast_ok !== m_t) begin
         errors++;
         $display("FAIL %s: fast_ok=%0b expected=%0b", tag, fast_ok, m_t);
      end
   endtask

   // one clock: inputs set at negedge, result sampled at the next negedge
   task automatic step(input logic v, input logic own, input logic [AW-1:0] a,
                       input logic [1:0] sp, input string tag);
      cyc_valid = v; bus_owner = own; addr = a; space = sp;
      model_step();
      @(posedge clk);
      @(negedge clk);
      check(tag);
   endtask

   initial begin
      m_lv = 0; m_t = 0; m_oq = 0; m_la = '0; m_ls = 2'b00;
      repeat (3) @(negedge clk);
      checks++;
      if (fast_ok !== 1'b0) begin
         errors++;
         $display("FAIL R1: fast_ok=%0b expected=0 in reset", fast_ok);
      end
      rst_n = 1'b1;
      @(negedge clk);
      m_oq = 1'b1;
      check("R1");
      // directed corner cases
      step(1, 1, 16'h0100, 2'b00, "R1");
      step(1, 1, 16'h0101, 2'b00, "R9");
      step(1, 1, 16'h0103, 2'b00, "R5");
      step(1, 1, 16'h0104, 2'b00, "R9");
      en_seq = 0;
      step(1, 1, 16'h010F, 2'b00, "R5");
      en_seq = 1;
      step(1, 1, 16'h0110, 2'b00, "R4");
      step(1, 1, 16'h0111, 2'b01, "R6");
      step(1, 1, 16'h0112, 2'b01, "R9");
      en_space_lo = 0;
      step(1, 1, 16'h0113, 2'b00, "R6");
      step(1, 1, 16'h0200, 2'b11, "R2");
      step(0, 1, 16'h0300, 2'b10, "R8");
      step(1, 1, 16'h0114, 2'b10, "R6");
      en_space_lo = 1;
      mon_ydat = 0;
      step(1, 1, 16'h0115, 2'b00, "R3");
      mon_ydat = 1;
      step(1, 1, 16'h0115, 2'b10, "R3");
      step(1, 1, 16'h0116, 2'b10, "R9");
      step(1, 0, 16'h0117, 2'b10, "R8");
      step(1, 1, 16'h0117, 2'b10, "R7");
      step(1, 1, 16'h0118, 2'b10, "R9");
      en_owner = 0;
      step(0, 0, 16'h0000, 2'b10, "R7");
      step(1, 1, 16'h0119, 2'b10, "R7");
      // constrained random stream
      void'($urandom(32'h5EED_0042));
      for (int i = 0; i < 3000; i++) begin
         int r;
         logic [AW-1:0] a;
         logic [1:0] sp;
         if (i % 16 == 0) begin
            en_seq = $urandom_range(0, 3) != 0;
            en_owner = $urandom_range(0, 1);
            en_space_hi = $urandom_range(0, 1);
            en_space_lo = $urandom_range(0, 1);
            mon_prog = $urandom_range(0, 4) != 0;
            mon_xdat = $urandom_range(0, 4) != 0;
            mon_ydat = $urandom_range(0, 4) != 0;
            case ($urandom_range(0, 2))
               0: page_mask = 16'hFFF0;
               1: page_mask = 16'hFF00;
               default: page_mask = 16'hFFFC;
            endcase
         end
         r = $urandom_range(0, 9);
         if (r < 6) a = m_la + 16'd1;
         else if (r < 8) a = (m_la & page_mask) | (16'($urandom) & ~page_mask);
         else a = 16'($urandom);
         sp = ($urandom_range(0, 5) == 0) ? 2'($urandom) : m_ls;
         step($urandom_range(0, 7) != 0, $urandom_range(0, 19) != 0, a, sp, "R9");
      end
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule